// File: doc/BRIEF.md
# DAC Code Register with Serial and Pulse Update Modes

This block owns the 8-bit code that sets a current-output DAC, and lets a host change that code in one of three ways. When chip select stays high through power-up, the block runs in pulse mode. Each clock pulse then moves the upper six bits of the code by one step. It counts upward only for as long as the data pin has stayed high since reset. Once the data pin has been seen low, the data level at each edge sets the step direction. When chip select is seen low at any time, the block switches for good to serial mode. In serial mode a framed transfer writes a new 8-bit code, and the code held before the transfer is shifted back out at the same time.

The pins are levels sampled on a fast system clock. Edges of the serial clock and of chip select are found by comparing each sample with the one before it. Every output is a register, so an output responds one system clock after the sample that caused the change. The host idles the serial clock low, and changes chip select only while the serial clock is low. A shutdown input freezes the code and raises a shutdown flag. Both mode latches clear only on the power-on reset.

Top module: `dac_tri_ctrl`

## Requirements
- R1: While the power-on reset is asserted, code is 8'h80 (mid-scale), dout_oe is 0, dout is 0 and shutdown is 0.
- R2: After reset the block is in pulse mode while cs_n is high. The first sample with cs_n low switches it to serial mode until the next reset. In serial mode a ser_clk rise with cs_n high leaves code unchanged. A ser_clk rise sampled together with the first cs_n low is not a step.
- R3: In pulse mode, with shdn_n high and cs_n high, each ser_clk rise changes code[7:2] by one, so code moves by 4. Bits code[1:0] keep their value. The new code appears one clock after the rise. While din has never been sampled low, every step goes up.
- R4: The first sample with din low switches pulse stepping to up/down until the next reset. After that, din high at a ser_clk rise steps up and din low steps down. A rise sampled together with the first din low still steps up.
- R5: In pulse mode code[7:2] stops at 63 when stepping up and at 0 when stepping down; it never wraps.
- R6: In serial mode din is captured on each ser_clk rise while cs_n is low, MSB first. When cs_n rises after exactly eight complete ser_clk pulses (rise then fall), code takes the captured byte one clock after the cs_n rise.
- R7: A serial frame with any number of complete ser_clk pulses other than eight leaves code unchanged.
- R8: dout_oe goes high one clock after cs_n falls and low one clock after cs_n rises. While it is high, dout shows the code held before the frame, MSB first: bit 7 right away, then one bit further after each ser_clk fall. After eight falls, dout continues with the captured din bits in the order they arrived. dout is 0 while dout_oe is low.
- R9: In pulse mode dout_oe stays low and dout stays 0.
- R10: shutdown equals the inverse of shdn_n one clock later. While shdn_n is low, neither a pulse step nor a serial commit changes code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ser_clk | input | 1 | Serial shift clock, or step pulse in pulse mode |
| cs_n | input | 1 | Chip select, active low; also selects the mode at power-up |
| din | input | 1 | Serial data in; step direction in pulse mode |
| shdn_n | input | 1 | Shutdown request, active low |
| code | output | 8 | Current DAC code |
| dout | output | 1 | Serial readback data |
| dout_oe | output | 1 | Output enable for the readback driver |
| shutdown | output | 1 | Shutdown flag for the analog section |

## Verification
Two events can land on the same sample. A pulse-mode step can meet the mode fallback: the bench lowers cs_n on the same sample where ser_clk rises, after a run of up steps. It then expects the code to stay put while the readback driver turns on. A step can also meet the direction fallback: din drops on the same sample as a rise in increment-only operation. Here the bench expects one more step up, and steps down from the next pulse onward. In both cases a behavioural model compares every output on every clock, and an explicit check of the absolute code value follows.

// File: rtl/dac_tri_pkg.sv
`timescale 1ns/1ps
package dac_tri_pkg;
  // Edge events found by comparing each pin sample with the one before it
  typedef struct packed {
    logic clk_rise;
    logic clk_fall;
    logic cs_fall;
    logic cs_rise;
  } pin_evt_t;
endpackage

// File: rtl/dac_pin_sampler.sv
`timescale 1ns/1ps
module dac_pin_sampler
  import dac_tri_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ser_clk,
  input  logic     cs_n,
  input  logic     din,
  output pin_evt_t evt,
  output logic     serial_eff,
  output logic     serial_q,
  output logic     up_only_q
);
  logic sclk_q;
  logic cs_n_q;

  // Sticky mode latches: only the power-on reset returns them to pulse / up-only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      serial_q  <= 1'b0;
      up_only_q <= 1'b1;
    end else begin
      sclk_q <= ser_clk;
      cs_n_q <= cs_n;
      if (!cs_n) serial_q  <= 1'b1;
      if (!din)  up_only_q <= 1'b0;
    end
  end

  assign evt.clk_rise = ser_clk & ~sclk_q;
  assign evt.clk_fall = ~ser_clk & sclk_q;
  assign evt.cs_fall  = ~cs_n & cs_n_q;
  assign evt.cs_rise  = cs_n & ~cs_n_q;
  // A CS low sample blocks stepping in the very sample it is first seen
  assign serial_eff   = serial_q | ~cs_n;
endmodule

// File: rtl/dac_serial_port.sv
`timescale 1ns/1ps
module dac_serial_port
  import dac_tri_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_evt_t          evt,
  input  logic              din,
  input  logic [CODE_W-1:0] cur_code,
  output logic              dout,
  output logic              dout_oe,
  output logic              commit,
  output logic [CODE_W-1:0] commit_code
);
  localparam int SH_W  = CODE_W + 1;
  localparam int CNT_W = $clog2(CODE_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_GOAL = CNT_W'(CODE_W);

  // Stage 0 captures on CLK rise; the whole chain moves on CLK fall.
  // The top stage drives DOUT, half a serial clock behind the capture.
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      falls   <= '0;
      dout_oe <= 1'b0;
    end else if (evt.cs_fall) begin
      sh      <= {cur_code, 1'b0};
      falls   <= '0;
      dout_oe <= 1'b1;
    end else if (evt.cs_rise) begin
      sh      <= '0;
      dout_oe <= 1'b0;
    end else if (dout_oe) begin
      if (evt.clk_rise) begin
        sh[0] <= din;
      end else if (evt.clk_fall) begin
        sh <= {sh[SH_W-2:0], 1'b0};
        if (falls != CNT_MAX) falls <= falls + 1'b1;
      end
    end
  end

  assign dout        = sh[SH_W-1];
  assign commit      = evt.cs_rise & dout_oe & (falls == CNT_GOAL);
  assign commit_code = sh[SH_W-1:1];
endmodule

// File: rtl/dac_pulse_step.sv
`timescale 1ns/1ps
module dac_pulse_step #(
  parameter int CODE_W   = 8,
  parameter int STEP_LSB = 2
) (
  input  logic [CODE_W-1:0] code_in,
  input  logic              up,
  output logic [CODE_W-1:0] code_out
);
  localparam int STEP_W = CODE_W - STEP_LSB;
  localparam logic [STEP_W-1:0] HI_MAX = '1;

  logic [STEP_W-1:0] hi;
  logic [STEP_W-1:0] hi_next;

  assign hi = code_in[CODE_W-1:STEP_LSB];

  // Saturating step of the upper field
  always_comb begin
    hi_next = hi;
    if (up) begin
      if (hi != HI_MAX) hi_next = hi + 1'b1;
    end else begin
      if (hi != '0) hi_next = hi - 1'b1;
    end
  end

  generate
    if (STEP_LSB > 0) begin : g_keep_low
      assign code_out = {hi_next, code_in[STEP_LSB-1:0]};
    end else begin : g_full
      assign code_out = hi_next;
    end
  endgenerate
endmodule

// File: rtl/dac_tri_ctrl.sv
`timescale 1ns/1ps
module dac_tri_ctrl
  import dac_tri_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int STEP_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              shdn_n,
  output logic [CODE_W-1:0] code,
  output logic              dout,
  output logic              dout_oe,
  output logic              shutdown
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  pin_evt_t          evt;
  logic              serial_eff;
  logic              serial_q;
  logic              up_only_q;
  logic              commit;
  logic [CODE_W-1:0] commit_code;
  logic [CODE_W-1:0] stepped;
  logic              pulse_fire;

  dac_pin_sampler u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk    (ser_clk),
    .cs_n       (cs_n),
    .din        (din),
    .evt        (evt),
    .serial_eff (serial_eff),
    .serial_q   (serial_q),
    .up_only_q  (up_only_q)
  );

  dac_serial_port #(.CODE_W(CODE_W)) u_serial (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .din         (din),
    .cur_code    (code),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .commit      (commit),
    .commit_code (commit_code)
  );

  // Latched up-only wins for the edge that meets the first DIN low
  dac_pulse_step #(.CODE_W(CODE_W), .STEP_LSB(STEP_LSB)) u_step (
    .code_in  (code),
    .up       (up_only_q | din),
    .code_out (stepped)
  );

  assign pulse_fire = evt.clk_rise & ~serial_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= MID_CODE;
      shutdown <= 1'b0;
    end else begin
      shutdown <= ~shdn_n;
      if (shdn_n) begin
        if (commit)          code <= commit_code;
        else if (pulse_fire) code <= stepped;
      end
    end
  end
endmodule

// File: rtl/dac_tri_ctrl_chk.sv
`timescale 1ns/1ps
module dac_tri_ctrl_chk #(
  parameter int CODE_W   = 8,
  parameter int STEP_LSB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n,
  input logic [CODE_W-1:0] code,
  input logic              dout_oe,
  input logic              shutdown,
  input logic              serial_q,
  input logic              up_only_q
);
  localparam logic [CODE_W-1:0] STEP = {{(CODE_W-1){1'b0}}, 1'b1} << STEP_LSB;

  assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serial_q |=> serial_q);

  assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_q |=> (code == $past(code)) || (code == $past(code) + STEP)
                  || (code == $past(code) - STEP));

  assert_dir_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !up_only_q |=> !up_only_q);

  assert_no_wrap_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_q && code[CODE_W-1:STEP_LSB] == '1) |=> code[CODE_W-1:STEP_LSB] != '0);

  assert_no_wrap_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_q && code[CODE_W-1:STEP_LSB] == '0) |=> code[CODE_W-1:STEP_LSB] != '1);

  assert_quiet_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_q |-> !dout_oe);

  assert_hold_shdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> code == $past(code));

  assert_flag_shdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> shutdown);
endmodule

bind dac_tri_ctrl dac_tri_ctrl_chk #(.CODE_W(CODE_W), .STEP_LSB(STEP_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shdn_n    (shdn_n),
  .code      (code),
  .dout_oe   (dout_oe),
  .shutdown  (shutdown),
  .serial_q  (serial_q),
  .up_only_q (up_only_q)
);

// File: tb/dac_tri_ctrl_tb.sv
`timescale 1ns/1ps
module dac_tri_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       cs_n = 1'b1;
  logic       din = 1'b1;
  logic       shdn_n = 1'b1;
  logic [7:0] code;
  logic       dout, dout_oe, shutdown;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dac_tri_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .cs_n(cs_n), .din(din),
    .shdn_n(shdn_n), .code(code), .dout(dout), .dout_oe(dout_oe), .shutdown(shutdown)
  );

  // Behavioural reference model
  logic [7:0] m_code = 8'h80;
  bit m_ser = 0, m_up = 1, m_psclk = 0, m_pcs = 1, m_oe = 0, m_dout = 0, m_shut = 0;
  int m_falls = 0;
  bit strm[$];

  always @(posedge clk) begin : model
    bit rise, fall, csf, csr, in_serial, up;
    int hi;
    if (!rst_n) begin
      m_code = 8'h80; m_ser = 0; m_up = 1; m_psclk = 0; m_pcs = 1;
      m_oe = 0; m_dout = 0; m_shut = 0; m_falls = 0; strm.delete();
    end else begin
      rise = ser_clk && !m_psclk;
      fall = !ser_clk && m_psclk;
      csf  = !cs_n && m_pcs;
      csr  = cs_n && !m_pcs;
      in_serial = m_ser || !cs_n;
      if (csf) begin
        strm.delete();
        for (int i = 7; i >= 0; i--) strm.push_back(m_code[i]);
        m_falls = 0; m_oe = 1; m_dout = m_code[7];
      end else if (csr) begin
        if (m_oe && m_falls == 8 && shdn_n && strm.size() >= 16)
          for (int i = 0; i < 8; i++) m_code[7-i] = strm[8+i];
        m_oe = 0; m_dout = 0;
      end else if (m_oe) begin
        if (rise) strm.push_back(din);
        if (fall) begin
          m_falls++;
          m_dout = (m_falls < strm.size()) ? strm[m_falls] : 1'b0;
        end
      end
      if (rise && !in_serial && shdn_n) begin
        up = m_up || din;
        hi = int'(m_code) / 4;
        if (up && hi < 63) hi++;
        if (!up && hi > 0) hi--;
        m_code = 8'(hi * 4 + int'(m_code) % 4);
      end
      m_psclk = ser_clk; m_pcs = cs_n;
      if (!cs_n) m_ser = 1;
      if (!din) m_up = 0;
      m_shut = !shdn_n;
    end
  end

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) if (!done) begin
    chk("code", int'(code), int'(m_code));
    chk("dout_oe", int'(dout_oe), int'(m_oe));
    chk("dout", int'(dout), int'(m_dout));
    chk("shutdown", int'(shutdown), int'(m_shut));
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic expect_code(logic [7:0] exp);
    @(negedge clk);
    chk("abs code", int'(code), int'(exp));
    #1;
  endtask

  task automatic powerup(bit cs_v, bit din_v);
    rst_n = 1'b0; ser_clk = 1'b0; shdn_n = 1'b1; cs_n = cs_v; din = din_v;
    tick(3);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic pulse(bit dir);
    din = dir; tick();
    ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic frame(logic [7:0] val, int nbits);
    cs_n = 1'b0; tick(2);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 8) ? val[7-i] : 1'b1;
      tick();
      ser_clk = 1'b1; tick(2);
      ser_clk = 1'b0; tick(2);
    end
    cs_n = 1'b1; tick(3);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Pulse mode, increment-only
    cur_req = "R1"; powerup(1'b1, 1'b1);
    expect_code(8'h80);
    cur_req = "R3";
    for (int i = 0; i < 3; i++) pulse(1'b1);
    expect_code(8'h8C);
    cur_req = "R9"; pulse(1'b1); expect_code(8'h90);
    cur_req = "R10"; shdn_n = 1'b0; tick(); pulse(1'b1); expect_code(8'h90);
    shdn_n = 1'b1; tick(2);
    // Direction fallback meeting a step: still up, then down
    cur_req = "R4";
    din = 1'b0; ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
    expect_code(8'h94);
    pulse(1'b0); pulse(1'b0); expect_code(8'h8C);
    pulse(1'b1); expect_code(8'h90);

    // Up/down from power-up, both saturation ends
    cur_req = "R5"; powerup(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) pulse(1'b0);
    expect_code(8'h00);
    for (int i = 0; i < 70; i++) pulse(1'b1);
    expect_code(8'hFC);

    // Increment-only saturation, then a late CS fall on a pulse edge
    cur_req = "R5"; powerup(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) pulse(1'b1);
    expect_code(8'hFC);
    pulse(1'b1); expect_code(8'hFC);
    cur_req = "R2";
    cs_n = 1'b0; ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
    cs_n = 1'b1; tick(3);
    expect_code(8'hFC);
    pulse(1'b1); pulse(1'b0); expect_code(8'hFC);
    cur_req = "R6"; frame(8'h5A, 8); expect_code(8'h5A);
    cur_req = "R8"; frame(8'hC3, 8); expect_code(8'hC3);

    // Serial from power-up
    cur_req = "R2"; powerup(1'b0, 1'b1);
    cs_n = 1'b1; tick(3);
    expect_code(8'h80);
    cur_req = "R6"; frame(8'h3C, 8); expect_code(8'h3C);
    cur_req = "R8"; frame(8'hA5, 8); expect_code(8'hA5);
    cur_req = "R7"; frame(8'h11, 7); expect_code(8'hA5);
    frame(8'h22, 9); expect_code(8'hA5);
    frame(8'h00, 0); expect_code(8'hA5);
    cur_req = "R10"; shdn_n = 1'b0; tick(); frame(8'h66, 8); expect_code(8'hA5);
    shdn_n = 1'b1; tick(2);
    frame(8'h66, 8); expect_code(8'h66);

    // Serial with DIN low at power-up
    cur_req = "R2"; powerup(1'b0, 1'b0);
    cs_n = 1'b1; tick(3);
    cur_req = "R6"; frame(8'hFF, 8); expect_code(8'hFF);
    cur_req = "R8"; frame(8'h01, 8); expect_code(8'h01);
    cur_req = "R2"; pulse(1'b1); pulse(1'b0); expect_code(8'h01);

    tick(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule